// File: doc/BRIEF.md
# Interrupt Pin Request and Service Unit

This unit sits between a group of interrupt input lines and a downstream dispatcher. Each line has its own configuration, supplied from a redirection table: a vector number, a trigger kind (edge or level), an active-low flag and a mask. Every cycle the unit samples the lines, applies each line's polarity and keeps one request bit per line. It also keeps a remote-pending lock for each level-triggered line. It offers one delivery at a time, made up of the line number, the vector and the trigger kind, on a valid/ready handshake. When several lines want service, the lowest line number goes first.

Level-triggered lines follow a lock protocol. Once a level line is delivered, it is locked until an end-of-interrupt message arrives carrying its vector. If the line is still asserted at that point, it is delivered again. Edge-triggered lines capture a rising effective level and drop the request once it is serviced. If the line is masked, the request is dropped without a delivery. The register block can send a per-line kick that releases a stuck lock and makes the line go through the service rule again.

The line inputs are taken to be synchronous to `clk`. At reset the previous-level register reads low, so an active-low line held low at reset shows up as a rising edge.

Top module: `irq_pin_service`

## Requirements
- R1: After reset no delivery is offered (`dlv_valid` low) until a line requests.
- R2: A line's effective level is its raw input XOR its active-low flag (`cfg_active_low` bit 1 = asserted when raw is 0).
- R3: An edge line (`cfg_level` bit 0) requests on a 0-to-1 change of its effective level. The request stays pending until it is accepted once. A level held high gives no further delivery.
- R4: A masked edge line (`cfg_mask` bit 1) drops its captured edge without a delivery. Unmasking it later brings no delivery.
- R5: A level line (`cfg_level` bit 1) is offered while its effective level is high, it is unmasked and its lock is clear. Acceptance sets the lock, and no further delivery of that line follows while the lock is set. When acceptance and a release reach the same line in the same cycle, the lock is set.
- R6: A level line's request follows its effective level. If the level drops before acceptance, the offer is withdrawn. A masked level line waits and is offered on unmask if it is still high.
- R7: An end-of-interrupt with vector V clears the lock of only the lowest-numbered line whose vector equals V. If that line is still high and unmasked, it is offered again.
- R8: An end-of-interrupt whose vector matches no line changes nothing.
- R9: A kick bit clears that line's lock, so a still-high unmasked level line is offered again.
- R10: At most one delivery is offered per cycle, for the lowest-numbered eligible line. `dlv_pin` is the line index, `dlv_vector` is its configured vector and `dlv_level` is its trigger kind.
- R11: While `dlv_ready` is low, a pending edge request is not lost and stays offered, unless a lower line takes precedence.
- R12: A change sampled at a rising clock edge shows on the delivery outputs right after that edge. An accepted offer (valid and ready high at an edge) is retired at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_raw | input | NPINS | Raw interrupt line levels |
| cfg_vector | input | NPINS*VEC_W | Vector per line, line i at bits [i*VEC_W +: VEC_W] |
| cfg_level | input | NPINS | Trigger kind per line, 1 = level, 0 = edge |
| cfg_active_low | input | NPINS | Polarity per line, 1 = active low |
| cfg_mask | input | NPINS | Mask per line, 1 = masked |
| kick | input | NPINS | One-cycle service request per line from the register block |
| eoi_valid | input | 1 | End-of-interrupt message present |
| eoi_vector | input | VEC_W | Vector carried by the end-of-interrupt |
| dlv_valid | output | 1 | Delivery offered |
| dlv_ready | input | 1 | Dispatcher accepts the offered delivery |
| dlv_pin | output | $clog2(NPINS) | Line index of the offer |
| dlv_vector | output | VEC_W | Vector of the offer |
| dlv_level | output | 1 | Trigger kind of the offer |

## Verification
All delivery outputs are derived by logic from state registered at one clock edge. A line change, an end-of-interrupt or a kick applied before an edge is therefore visible right after that edge, with no further cycle of delay. An accepted offer is retired at the same edge where valid and ready were both high. The bench changes its inputs just after a rising edge and checks the outputs one nanosecond after the next rising edge. Every expected value in the table is worked out for that single-edge timing.

// File: rtl/irq_svc_pkg.sv
package irq_svc_pkg;

    // Index width for a set of n lines, at least one bit.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/irq_lowest_first.sv
module irq_lowest_first #(
    parameter int N  = 8,
    parameter int IW = irq_svc_pkg::idx_width(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_eoi_match.sv
module irq_eoi_match #(
    parameter int N     = 8,
    parameter int VEC_W = 8,
    localparam int IW   = irq_svc_pkg::idx_width(N)
) (
    input  logic [N*VEC_W-1:0] cfg_vector,
    input  logic               eoi_valid,
    input  logic [VEC_W-1:0]   eoi_vector,
    output logic [N-1:0]       clr
);
    logic [N-1:0]  hit;
    logic          hit_any;
    logic [IW-1:0] hit_idx;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = eoi_valid && (cfg_vector[g*VEC_W +: VEC_W] == eoi_vector);
    end

    irq_lowest_first #(.N(N), .IW(IW)) u_pick (
        .req (hit),
        .any (hit_any),
        .idx (hit_idx)
    );

    for (genvar g = 0; g < N; g++) begin : g_sel
        assign clr[g] = hit_any && (hit_idx == IW'(g));
    end
endmodule

// File: rtl/irq_pin_service.sv
module irq_pin_service #(
    parameter int NPINS = 8,
    parameter int VEC_W = 8,
    localparam int IW   = irq_svc_pkg::idx_width(NPINS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NPINS-1:0]       pin_raw,
    input  logic [NPINS*VEC_W-1:0] cfg_vector,
    input  logic [NPINS-1:0]       cfg_level,
    input  logic [NPINS-1:0]       cfg_active_low,
    input  logic [NPINS-1:0]       cfg_mask,
    input  logic [NPINS-1:0]       kick,
    input  logic                   eoi_valid,
    input  logic [VEC_W-1:0]       eoi_vector,
    output logic                   dlv_valid,
    input  logic                   dlv_ready,
    output logic [IW-1:0]          dlv_pin,
    output logic [VEC_W-1:0]       dlv_vector,
    output logic                   dlv_level
);
    typedef struct packed {
        logic [NPINS-1:0] lvl;   // effective level seen at the previous edge
        logic [NPINS-1:0] irr;   // request bits
        logic [NPINS-1:0] lock;  // remote-pending lock for level lines
    } state_t;

    state_t st_d, st_q;

    logic [NPINS-1:0] eff;
    logic [NPINS-1:0] eligible;
    logic [NPINS-1:0] eoi_clr;
    logic [NPINS-1:0] gnt_oh;
    logic             gnt_any;
    logic [IW-1:0]    gnt_idx;
    logic             fire;

    assign eff = pin_raw ^ cfg_active_low;

    // Edge lines need only a request; level lines also need a clear lock.
    assign eligible = st_q.irr & ~cfg_mask & ~(cfg_level & st_q.lock);

    irq_lowest_first #(.N(NPINS), .IW(IW)) u_grant (
        .req (eligible),
        .any (gnt_any),
        .idx (gnt_idx)
    );

    irq_eoi_match #(.N(NPINS), .VEC_W(VEC_W)) u_eoi (
        .cfg_vector (cfg_vector),
        .eoi_valid  (eoi_valid),
        .eoi_vector (eoi_vector),
        .clr        (eoi_clr)
    );

    assign fire = gnt_any && dlv_ready;

    for (genvar g = 0; g < NPINS; g++) begin : g_oh
        assign gnt_oh[g] = fire && (gnt_idx == IW'(g));
    end

    always_comb begin
        st_d     = st_q;
        st_d.lvl = eff;
        for (int i = 0; i < NPINS; i++) begin
            if (cfg_level[i]) begin
                st_d.irr[i] = eff[i];
            end else begin
                // a new rising edge wins over retirement or mask drop
                st_d.irr[i] = (st_q.irr[i] && !gnt_oh[i] && !cfg_mask[i])
                            || (eff[i] && !st_q.lvl[i]);
            end
            // acceptance of a level line sets the lock over any release
            st_d.lock[i] = (st_q.lock[i] && !eoi_clr[i] && !kick[i])
                         || (gnt_oh[i] && cfg_level[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dlv_valid  = gnt_any;
    assign dlv_pin    = gnt_idx;
    assign dlv_vector = cfg_vector[int'(gnt_idx)*VEC_W +: VEC_W];
    assign dlv_level  = cfg_level[gnt_idx];
endmodule

// File: rtl/irq_pin_service_chk.sv
module irq_pin_service_chk #(
    parameter int NPINS = 8,
    parameter int VEC_W = 8,
    localparam int IW   = irq_svc_pkg::idx_width(NPINS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPINS-1:0] cfg_level,
    input logic [NPINS-1:0] cfg_mask,
    input logic             dlv_valid,
    input logic             dlv_ready,
    input logic [IW-1:0]    dlv_pin,
    input logic             dlv_level
);
    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !dlv_valid);

    assert_never_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> !cfg_mask[dlv_pin]);

    assert_level_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && dlv_ready && dlv_level)
        |=> !(dlv_valid && dlv_level && dlv_pin == $past(dlv_pin)));

    assert_edge_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && !dlv_ready && !dlv_level)
        |=> (dlv_valid && dlv_pin <= $past(dlv_pin))
            || (cfg_mask != $past(cfg_mask))
            || (cfg_level != $past(cfg_level)));
endmodule

bind irq_pin_service irq_pin_service_chk #(.NPINS(NPINS), .VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_level (cfg_level),
    .cfg_mask  (cfg_mask),
    .dlv_valid (dlv_valid),
    .dlv_ready (dlv_ready),
    .dlv_pin   (dlv_pin),
    .dlv_level (dlv_level)
);

// File: tb/sim_irq_pin_service.sv
`timescale 1ns/1ps
module sim_irq_pin_service;
    localparam int NP = 8;
    localparam int VW = 8;
    localparam int NSTEP = 21;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NP-1:0]  pin_raw = 8'h0A;
    logic [NP*VW-1:0] cfg_vector;
    logic [NP-1:0]  cfg_level = 8'b0100_1100;
    logic [NP-1:0]  cfg_active_low = 8'b0000_1010;
    logic [NP-1:0]  cfg_mask = '0;
    logic [NP-1:0]  kick = '0;
    logic           eoi_valid = 1'b0;
    logic [VW-1:0]  eoi_vector = '0;
    logic           dlv_valid;
    logic           dlv_ready = 1'b0;
    logic [2:0]     dlv_pin;
    logic [VW-1:0]  dlv_vector;
    logic           dlv_level;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_pin_service #(.NPINS(NP), .VEC_W(VW)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .cfg_vector(cfg_vector),
        .cfg_level(cfg_level), .cfg_active_low(cfg_active_low), .cfg_mask(cfg_mask),
        .kick(kick), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_pin(dlv_pin),
        .dlv_vector(dlv_vector), .dlv_level(dlv_level)
    );

    // Lines 2 and 6 share vector 8'h32; others carry 8'h30 + index.
    function automatic logic [VW-1:0] exp_vec(input int p);
        return (p == 6) ? 8'h32 : 8'(8'h30 + p);
    endfunction

    // {raw, eoi_valid, eoi_vector, ready, exp_valid, exp_pin}
    localparam logic [21:0] TBL [NSTEP] = '{
        {8'h0A, 1'b0, 8'h00, 1'b0, 1'b0, 3'd0},
        {8'h1A, 1'b0, 8'h00, 1'b0, 1'b1, 3'd4},
        {8'h1A, 1'b0, 8'h00, 1'b0, 1'b1, 3'd4},
        {8'h1B, 1'b0, 8'h00, 1'b0, 1'b1, 3'd0},
        {8'h1B, 1'b0, 8'h00, 1'b1, 1'b1, 3'd4},
        {8'h1B, 1'b0, 8'h00, 1'b1, 1'b0, 3'd0},
        {8'h1F, 1'b0, 8'h00, 1'b0, 1'b1, 3'd2},
        {8'h1F, 1'b0, 8'h00, 1'b1, 1'b0, 3'd0},
        {8'h1F, 1'b0, 8'h00, 1'b1, 1'b0, 3'd0},
        {8'h1F, 1'b1, 8'h32, 1'b0, 1'b1, 3'd2},
        {8'h1F, 1'b0, 8'h00, 1'b1, 1'b0, 3'd0},
        {8'h5F, 1'b0, 8'h00, 1'b1, 1'b1, 3'd6},
        {8'h5F, 1'b0, 8'h00, 1'b1, 1'b0, 3'd0},
        {8'h5F, 1'b1, 8'h32, 1'b0, 1'b1, 3'd2},
        {8'h5F, 1'b0, 8'h00, 1'b1, 1'b0, 3'd0},
        {8'h5F, 1'b1, 8'h77, 1'b1, 1'b0, 3'd0},
        {8'h57, 1'b0, 8'h00, 1'b0, 1'b1, 3'd3},
        {8'h5F, 1'b0, 8'h00, 1'b0, 1'b0, 3'd0},
        {8'h5D, 1'b0, 8'h00, 1'b0, 1'b1, 3'd1},
        {8'h5F, 1'b0, 8'h00, 1'b0, 1'b1, 3'd1},
        {8'h5F, 1'b0, 8'h00, 1'b1, 1'b0, 3'd0}
    };

    function automatic string row_tag(input int s);
        case (s)
            0:                 return "R1";
            1:                 return "R12";
            2:                 return "R11";
            3, 4:              return "R10";
            5, 19, 20:         return "R3";
            6, 7, 8, 10, 11, 12: return "R5";
            9, 13, 14:         return "R7";
            15:                return "R8";
            16, 18:            return "R2";
            default:           return "R6";
        endcase
    endfunction

    task automatic check(input string tag, input logic ev, input int ep);
        n_run++;
        if (dlv_valid !== ev || (ev && dlv_pin !== 3'(ep))) begin
            n_fail++;
            $display("FAIL %s: valid=%0b pin=%0d expected valid=%0b pin=%0d",
                     tag, dlv_valid, dlv_pin, ev, ep);
        end else if (ev && (dlv_vector !== exp_vec(ep) || dlv_level !== cfg_level[ep])) begin
            n_fail++;
            $display("FAIL %s: vector=%h level=%0b expected vector=%h level=%0b",
                     tag, dlv_vector, dlv_level, exp_vec(ep), cfg_level[ep]);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        for (int i = 0; i < NP; i++) cfg_vector[i*VW +: VW] = exp_vec(i);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        check("R1", 1'b0, 0);

        for (int s = 0; s < NSTEP; s++) begin
            pin_raw    = TBL[s][21:14];
            eoi_valid  = TBL[s][13];
            eoi_vector = TBL[s][12:5];
            dlv_ready  = TBL[s][4];
            step();
            check(row_tag(s), TBL[s][3], int'(TBL[s][2:0]));
        end
        eoi_valid = 1'b0;

        // R4: masked edge on line 7 is dropped and not delivered on unmask
        cfg_mask[7] = 1'b1; pin_raw = 8'hDF; dlv_ready = 1'b1;
        step(); check("R4", 1'b0, 0);
        step(); check("R4", 1'b0, 0);
        cfg_mask[7] = 1'b0;
        step(); check("R4", 1'b0, 0);

        // R9: kick releases the lock on line 6, still high
        dlv_ready = 1'b0; kick = 8'h40;
        step(); check("R9", 1'b1, 6);
        kick = '0;
        // R6: masked level line waits, offered again on unmask
        cfg_mask[6] = 1'b1;
        step(); check("R6", 1'b0, 0);
        cfg_mask[6] = 1'b0;
        step(); check("R6", 1'b1, 6);
        dlv_ready = 1'b1;
        step(); check("R5", 1'b0, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule